// File: doc/BRIEF.md
# Double-Buffered Multichannel DAC Register Front End

This block is the digital register side of a sixteen-channel, eight-bit multiplying DAC. A parallel bus loads one channel at a time. The bus has an 8-bit bidirectional data path, a 4-bit channel address, an active-low chip select, a read/write line, an enable strobe, a load line and a reset. Each channel has two register ranks. Writes go into the first rank, the input registers. A single global load strobe copies all sixteen input registers into the second rank, the DAC registers, on the same clock edge. Every output code therefore changes together.

The bus is sampled on the block clock. A strobe is the clock edge where `en_i` is seen high after being seen low on the previous edge. Readback drives the addressed input register onto the shared data bus while a read is in progress. The bus is left at high impedance at all other times. The asynchronous reset clears only the DAC register rank, so the outputs go to code zero while the staged input values survive.

Top module: `dac_front_end`

## Requirements
- R1: There are 16 channels, each holding an 8-bit input register and an 8-bit DAC register. DAC register k appears on `dac_codes_o[8k+7:8k]`, so channel 0 is the least significant byte.
- R2: A write is an enable strobe (`en_i` sampled low on one rising clock edge and high on the next) with `cs_ni` low and `rd_wr_i` low. On that edge, input register `addr_i` captures `data_io` and no other input register changes. A write alone leaves `dac_codes_o` unchanged.
- R3: Only the rising transition of enable acts. An enable pulse that is high for a single clock cycle completes a write. Keeping enable high for further cycles while the data changes stores nothing more.
- R4: An enable strobe with `ld_i` high copies all 16 input registers into the DAC registers, so `dac_codes_o` holds the new codes one clock edge after the strobe. `dac_codes_o` changes at no other edge except through reset.
- R5: If a write and a load share one enable strobe, the DAC register of the written channel takes that input register's value from before the write. The new value reaches the DAC register only at a later load.
- R6: An enable strobe with `cs_ni` high, or with `rd_wr_i` high, changes no input register.
- R7: While `rst_ni` is low, every DAC register is zero immediately, without waiting for a clock, and a load strobe has no effect. Input registers keep their contents through reset.
- R8: While `rd_wr_i` is high, `cs_ni` is low and `en_i` is high, the block drives `data_io` with input register `addr_i`. At all other times it leaves `data_io` at high impedance.
- R9: The load acts whatever the levels of `cs_ni` and `rd_wr_i`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Block clock; all bus inputs are sampled on its rising edge |
| rst_ni | input | 1 | Active-low asynchronous reset; clears DAC registers |
| cs_ni | input | 1 | Active-low chip select for writes and readback |
| rd_wr_i | input | 1 | 1 = read, 0 = write |
| en_i | input | 1 | Enable; its sampled rising transition is the bus strobe |
| ld_i | input | 1 | Load line; with an enable strobe, transfers all input registers to DAC registers |
| addr_i | input | 4 | Channel address for write and readback |
| data_io | inout | 8 | Bidirectional data bus; driven by the block only during readback |
| dac_codes_o | output | 128 | Sixteen DAC register codes, channel 0 in bits 7:0 |

## Verification
A corrupt input register stays hidden at the outputs until the next load. It can be seen earlier only by reading the channel back over the bus, so the bench reads back after every batch of writes and after each ignored write. A corrupt DAC register or a misplaced load shows on `dac_codes_o` at the very next clock edge, so the outputs are compared with a behavioural model on every cycle. A wrong ordering between write and load on a shared strobe shows only on the written channel's byte, one edge after that strobe.

// File: rtl/dac_fe_pkg.sv
package dac_fe_pkg;
  localparam int unsigned NUM_CH = 16;
  localparam int unsigned CODE_W = 8;
  localparam int unsigned ADDR_W = $clog2(NUM_CH);
  typedef logic [CODE_W-1:0] code_t;
endpackage

// File: rtl/dac_bus_decode.sv
module dac_bus_decode #(
  parameter int unsigned NUM_CH = dac_fe_pkg::NUM_CH,
  localparam int unsigned AW = $clog2(NUM_CH)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cs_ni,
  input  logic              rd_wr_i,
  input  logic              en_i,
  input  logic              ld_i,
  input  logic [AW-1:0]     addr_i,
  output logic [NUM_CH-1:0] wr_sel_o,
  output logic              load_o,
  output logic              read_o,
  output logic              en_rise_o
);
  logic en_q;
  logic wr_stb;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) en_q <= 1'b0;
    else         en_q <= en_i;
  end

  assign en_rise_o = en_i & ~en_q;
  assign wr_stb    = en_rise_o & ~cs_ni & ~rd_wr_i;
  assign load_o    = en_rise_o & ld_i;
  assign read_o    = rd_wr_i & ~cs_ni & en_i;

  for (genvar k = 0; k < NUM_CH; k++) begin : g_sel
    assign wr_sel_o[k] = wr_stb && (addr_i == AW'(k));
  end
endmodule

// File: rtl/dac_channel.sv
module dac_channel #(
  parameter int unsigned DW = dac_fe_pkg::CODE_W
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          wr_i,
  input  logic          load_i,
  input  logic [DW-1:0] data_i,
  output logic [DW-1:0] in_o,
  output logic [DW-1:0] dac_o
);
  logic [DW-1:0] in_q;
  logic [DW-1:0] dac_q;

  // staging rank deliberately has no reset
  always_ff @(posedge clk_i) begin
    if (wr_i) in_q <= data_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     dac_q <= '0;
    else if (load_i) dac_q <= in_q;
  end

  assign in_o  = in_q;
  assign dac_o = dac_q;
endmodule

// File: rtl/dac_readback.sv
module dac_readback #(
  parameter int unsigned NUM_CH = dac_fe_pkg::NUM_CH,
  parameter int unsigned DW     = dac_fe_pkg::CODE_W,
  localparam int unsigned AW    = $clog2(NUM_CH)
) (
  input  logic [NUM_CH*DW-1:0] in_flat_i,
  input  logic [AW-1:0]        addr_i,
  output logic [DW-1:0]        data_o
);
  always_comb begin
    data_o = '0;
    for (int k = 0; k < NUM_CH; k++) begin
      if (addr_i == AW'(k)) data_o = in_flat_i[k*DW +: DW];
    end
  end
endmodule

// File: rtl/dac_front_end.sv
module dac_front_end #(
  parameter int unsigned NUM_CH = dac_fe_pkg::NUM_CH,
  parameter int unsigned DW     = dac_fe_pkg::CODE_W,
  localparam int unsigned AW    = $clog2(NUM_CH)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cs_ni,
  input  logic              rd_wr_i,
  input  logic              en_i,
  input  logic              ld_i,
  input  logic [AW-1:0]     addr_i,
  inout  wire  [DW-1:0]     data_io,
  output logic [NUM_CH*DW-1:0] dac_codes_o
);
  logic [NUM_CH-1:0]    wr_sel;
  logic                 load;
  logic                 read;
  logic                 en_rise;
  logic [NUM_CH*DW-1:0] in_codes;
  logic [DW-1:0]        rd_data;

  dac_bus_decode #(.NUM_CH(NUM_CH)) i_decode (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .cs_ni     (cs_ni),
    .rd_wr_i   (rd_wr_i),
    .en_i      (en_i),
    .ld_i      (ld_i),
    .addr_i    (addr_i),
    .wr_sel_o  (wr_sel),
    .load_o    (load),
    .read_o    (read),
    .en_rise_o (en_rise)
  );

  for (genvar k = 0; k < NUM_CH; k++) begin : g_ch
    dac_channel #(.DW(DW)) i_ch (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .wr_i   (wr_sel[k]),
      .load_i (load),
      .data_i (data_io),
      .in_o   (in_codes[k*DW +: DW]),
      .dac_o  (dac_codes_o[k*DW +: DW])
    );
  end

  dac_readback #(.NUM_CH(NUM_CH), .DW(DW)) i_rb (
    .in_flat_i (in_codes),
    .addr_i    (addr_i),
    .data_o    (rd_data)
  );

  assign data_io = read ? rd_data : {DW{1'bz}};
endmodule

// File: rtl/dac_front_end_chk.sv
module dac_front_end_chk #(
  parameter int unsigned NUM_CH = dac_fe_pkg::NUM_CH,
  parameter int unsigned DW     = dac_fe_pkg::CODE_W,
  localparam int unsigned AW    = $clog2(NUM_CH)
) (
  input logic                 clk_i,
  input logic                 rst_ni,
  input logic                 cs_ni,
  input logic                 rd_wr_i,
  input logic [AW-1:0]        addr_i,
  input logic [DW-1:0]        data_io,
  input logic                 en_rise,
  input logic                 load,
  input logic                 read,
  input logic [NUM_CH-1:0]    wr_sel,
  input logic [NUM_CH*DW-1:0] in_codes,
  input logic [NUM_CH*DW-1:0] dac_codes_o
);
  AST_ONE_TARGET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(wr_sel)); // R2

  AST_LOAD_COPIES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load |=> dac_codes_o == $past(in_codes)); // R4

  AST_DAC_HELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !load |=> $stable(dac_codes_o)); // R4

  AST_UNSEL_IGNORED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_rise && (cs_ni || rd_wr_i)) |=> $stable(in_codes)); // R6

  AST_RESET_ZERO: assert property (@(posedge clk_i)
    !rst_ni |-> dac_codes_o == '0); // R7

  AST_READ_DATA: assert property (@(posedge clk_i) disable iff (!rst_ni)
    read |-> data_io == in_codes[int'(addr_i)*DW +: DW]); // R8
endmodule

bind dac_front_end dac_front_end_chk #(.NUM_CH(NUM_CH), .DW(DW)) i_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .cs_ni       (cs_ni),
  .rd_wr_i     (rd_wr_i),
  .addr_i      (addr_i),
  .data_io     (data_io),
  .en_rise     (en_rise),
  .load        (load),
  .read        (read),
  .wr_sel      (wr_sel),
  .in_codes    (in_codes),
  .dac_codes_o (dac_codes_o)
);

// File: tb/test_dac_front_end.sv
`timescale 1ns/1ps
module test_dac_front_end;
  localparam int NCH = 16;

  logic         clk = 1'b0;
  logic         rst_ni = 1'b0;
  logic         cs_ni = 1'b1;
  logic         rd_wr_i = 1'b0;
  logic         en_i = 1'b0;
  logic         ld_i = 1'b0;
  logic [3:0]   addr_i = '0;
  logic [7:0]   tb_d = '0;
  logic         tb_drv = 1'b0;
  wire  [7:0]   data_io;
  logic [127:0] dac_codes_o;

  logic [7:0] in_m  [NCH];
  logic [7:0] dac_m [NCH];
  int compared = 0;
  int mismatched = 0;
  int cycles = 0;
  bit running = 1'b0;

  always #4 clk = ~clk;

  assign data_io = tb_drv ? tb_d : 8'hzz;
  for (genvar b = 0; b < 8; b++) begin : g_pu
    pullup (data_io[b]);
  end

  dac_front_end i_dac_front_end (
    .clk_i       (clk),
    .rst_ni      (rst_ni),
    .cs_ni       (cs_ni),
    .rd_wr_i     (rd_wr_i),
    .en_i        (en_i),
    .ld_i        (ld_i),
    .addr_i      (addr_i),
    .data_io     (data_io),
    .dac_codes_o (dac_codes_o)
  );

  function automatic logic [127:0] model_flat();
    logic [127:0] v;
    for (int k = 0; k < NCH; k++) v[k*8 +: 8] = dac_m[k];
    return v;
  endfunction

  task automatic check8(string tag, logic [7:0] act, logic [7:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s actual=%02h expected=%02h", tag, act, exp);
    end
  endtask

  task automatic check128(string tag, logic [127:0] act, logic [127:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s actual=%032h expected=%032h", tag, act, exp);
    end
  endtask

  // R1 R4: per-cycle comparison of every output byte with the model
  always @(negedge clk) begin
    if (running) check128("R1/R4 per-cycle outputs", dac_codes_o, model_flat());
  end

  // one enable strobe; model: load copies pre-write inputs (R5)
  task automatic bus_cycle(logic cs_n, logic rw, logic [3:0] a, logic [7:0] d, logic ld);
    @(negedge clk);
    cs_ni = cs_n; rd_wr_i = rw; addr_i = a; ld_i = ld; en_i = 1'b1;
    tb_d = d; tb_drv = !rw;
    @(posedge clk);
    if (ld && rst_ni) for (int k = 0; k < NCH; k++) dac_m[k] = in_m[k];
    if (!cs_n && !rw) in_m[a] = d;
    @(negedge clk);
    en_i = 1'b0; cs_ni = 1'b1; ld_i = 1'b0; tb_drv = 1'b0; rd_wr_i = 1'b0;
  endtask

  task automatic bus_read(string tag, logic [3:0] a);
    @(negedge clk);
    tb_drv = 1'b0; cs_ni = 1'b0; rd_wr_i = 1'b1; addr_i = a; ld_i = 1'b0; en_i = 1'b1;
    #2 check8(tag, data_io, in_m[a]);
    @(negedge clk);
    en_i = 1'b0; cs_ni = 1'b1; rd_wr_i = 1'b0;
  endtask

  initial begin
    for (int k = 0; k < NCH; k++) begin in_m[k] = '0; dac_m[k] = '0; end
    repeat (3) @(negedge clk);
    #1 check128("R7 outputs zero in reset", dac_codes_o, '0);
    @(negedge clk); #2 rst_ni = 1'b1;
    running = 1'b1;
    @(negedge clk); #1 check8("R8 bus released when idle", data_io, 8'hff);

    // R2: fill every channel; DAC rank must stay at zero
    for (int k = 0; k < NCH; k++) bus_cycle(1'b0, 1'b0, 4'(k), 8'((k * 37 + 9) & 8'hff), 1'b0);
    bus_cycle(1'b0, 1'b0, 4'd5, 8'h00, 1'b0);
    @(negedge clk); #1 check128("R2 write alone keeps outputs", dac_codes_o, '0);
    for (int k = 0; k < NCH; k++) bus_read("R2/R8 readback after write", 4'(k));
    @(negedge clk); #1 check8("R8 bus released after read", data_io, 8'hff);

    // R4 R9: load with chip select inactive and read/write high
    bus_cycle(1'b1, 1'b1, 4'd0, 8'h00, 1'b1);
    @(negedge clk); #1 check128("R4/R9 load transfers all", dac_codes_o, model_flat());

    // R6: ignored writes
    bus_cycle(1'b1, 1'b0, 4'd3, 8'hee, 1'b0);
    bus_cycle(1'b0, 1'b1, 4'd4, 8'hee, 1'b0);
    bus_read("R6 deselected write ignored", 4'd3);
    bus_read("R6 read-mode strobe ignored", 4'd4);

    // R5: write and load on the same strobe
    begin
      logic [7:0] old7;
      old7 = in_m[7];
      bus_cycle(1'b0, 1'b0, 4'd7, 8'h5a, 1'b1);
      @(negedge clk); #1 check8("R5 same-strobe load takes old value", dac_codes_o[63:56], old7);
      bus_cycle(1'b1, 1'b0, 4'd0, 8'h00, 1'b1);
      @(negedge clk); #1 check8("R5 new value after next load", dac_codes_o[63:56], 8'h5a);
    end

    // R3: long enable pulse with changing data stores only the first value
    @(negedge clk);
    cs_ni = 1'b0; rd_wr_i = 1'b0; addr_i = 4'd9; tb_d = 8'h3c; tb_drv = 1'b1; en_i = 1'b1;
    @(posedge clk); in_m[9] = 8'h3c;
    @(negedge clk); tb_d = 8'hc3;
    @(negedge clk); tb_d = 8'h77;
    @(negedge clk); en_i = 1'b0; cs_ni = 1'b1; tb_drv = 1'b0;
    bus_read("R3 only rising enable writes", 4'd9);
    // R3: single-cycle pulses back to back
    bus_cycle(1'b0, 1'b0, 4'd10, 8'h81, 1'b0);
    bus_cycle(1'b0, 1'b0, 4'd11, 8'h42, 1'b0);
    bus_read("R3 short pulse write ch10", 4'd10);
    bus_read("R3 short pulse write ch11", 4'd11);
    bus_cycle(1'b0, 1'b1, 4'd0, 8'h00, 1'b1);

    // R7: asynchronous reset, load ignored, inputs retained
    @(negedge clk); #2 rst_ni = 1'b0;
    #1 check128("R7 async clear", dac_codes_o, '0);
    for (int k = 0; k < NCH; k++) dac_m[k] = '0;
    bus_cycle(1'b1, 1'b0, 4'd0, 8'h00, 1'b1);
    @(negedge clk); #1 check128("R7 load ignored in reset", dac_codes_o, '0);
    #1 rst_ni = 1'b1;
    for (int k = 0; k < NCH; k++) bus_read("R7 inputs kept through reset", 4'(k));
    bus_cycle(1'b1, 1'b1, 4'd0, 8'h00, 1'b1);
    @(negedge clk); #1 check128("R7 reload after reset", dac_codes_o, model_flat());

    running = 1'b0;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000) begin
      mismatched++;
      $display("FAIL R3 watchdog actual=%0d cycles expected<=20000", cycles);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end
endmodule